// File: doc/BRIEF.md
# Stride Load Address Predictor

This block guesses the effective address of a load before the address is computed. It also guesses which cache line that address will touch. A direct-mapped table is indexed by low bits of the instruction address. Each entry remembers the last address its load produced, the step between the last two addresses, and a two-bit confidence counter. The front end presents the fetch program counter on the lookup port. One cycle later, in the decode stage, the block returns the predicted address (last plus step), the cache line that address hashes to, and a flag that says whether the guess is trusted enough for a speculative cache access.

The line hash is a fixed XOR fold of the address bits above the line offset. It is computed in the same cycle as the add. When the load's real address is known, the memory stage presents it on the update port. In the same cycle the block reports whether a speculative access made with the predicted line has to be replayed. It then trains the entry. The last address is always overwritten. The confidence moves one step toward trust or distrust. The step is relearned only once confidence has dropped into the low half. Entries carry no tag, so loads that share index bits share an entry.

Top module: `ldp_stride_pred`

## Requirements
- R1: While reset is asserted, and afterwards until an entry is retrained, every confidence counter reads zero: `pr_use` is 0 and `pr_valid` is 0 during reset. The asynchronous active-low reset is released through a two-flop synchronizer.
- R2: `pr_valid` equals `lk_valid` of the previous cycle. `pr_addr` equals the selected entry's last address plus its step, taken from the table state before any update in the same cycle.
- R3: `pr_line` is 8 bits. Bit i is the XOR of every address bit at position 5+i+8k (k = 0,1,2,...) that lies below bit 32.
- R4: `pr_use` is 1 exactly when `pr_valid` is 1 and the entry's counter is 2 or 3 (most significant bit set).
- R5: The entry index is `pc[11:2]`. There is no tag, so program counters that differ only outside those bits read and train the same entry.
- R6: `up_replay` is combinational. It is 1 exactly when `up_valid` is 1, the entry's counter before the update is 2 or 3, and the hash of the predicted address differs from the hash of `up_addr`. A wrong address within the same line gives 0.
- R7: Every valid update overwrites the entry's last address with `up_addr`, whether the prediction was right or wrong.
- R8: A valid update raises the counter by one when `up_addr` equals the predicted address, and lowers it by one otherwise. The counter saturates at 3 and at 0.
- R9: On a wrong prediction whose lowered counter is below binary 10, the step becomes `up_addr` minus the old last address. In every other case the step is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request from fetch |
| lk_pc | input | 32 | Program counter of the load being fetched |
| pr_valid | output | 1 | Prediction outputs are valid (one cycle after lookup) |
| pr_addr | output | 32 | Predicted effective address |
| pr_line | output | 8 | Hashed cache line of the predicted address |
| pr_use | output | 1 | Prediction is confident enough to access the cache |
| up_valid | input | 1 | Resolved load presented for check and training |
| up_pc | input | 32 | Program counter of the resolved load |
| up_addr | input | 32 | Real effective address of the resolved load |
| up_replay | output | 1 | Speculative access used a wrong line and must be repeated |

## Verification
The in-RTL assertions check these rules on every cycle:
- the one-cycle timing of the prediction valid;
- that the use and replay flags never appear without their requests;
- counter saturation at both ends;
- that a written entry holds the new last address;
- that its step is left alone when retraining is not allowed;
- that its counter moves by at most one.

Only the bench's scenarios show the rest:
- the learning sequence of a stride stream;
- the two-miss delay before the step is relearned;
- the split between a wrong address in the same line (no replay) and a wrong line (replay);
- aliasing of untagged entries;
- read-before-write when lookup and update hit one entry in the same cycle.

// File: rtl/ldp_pkg.sv
package ldp_pkg;

  typedef logic [1:0] conf_t;

  localparam conf_t CONF_MIN = 2'd0;
  localparam conf_t CONF_MAX = 2'd3;
  localparam conf_t CONF_USE = 2'b10;

  // one saturating step of the confidence counter
  function automatic conf_t conf_step(input conf_t c, input logic good);
    conf_t r;
    if (good) r = (c == CONF_MAX) ? CONF_MAX : c + 2'd1;
    else      r = (c == CONF_MIN) ? CONF_MIN : c - 2'd1;
    return r;
  endfunction

endpackage

// File: rtl/ldp_hash.sv
module ldp_hash #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 5,
  parameter int LINE_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [LINE_W-1:0] line
);

  localparam int FOLDS = (ADDR_W - OFS_W + LINE_W - 1) / LINE_W;

  logic [LINE_W-1:0][FOLDS-1:0] term;

  for (genvar i = 0; i < LINE_W; i++) begin : g_bit
    for (genvar k = 0; k < FOLDS; k++) begin : g_fold
      localparam int POS = OFS_W + i + k * LINE_W;
      if (POS < ADDR_W) begin : g_tap
        assign term[i][k] = addr[POS];
      end else begin : g_pad
        assign term[i][k] = 1'b0;
      end
    end
    assign line[i] = ^term[i];
  end

endmodule

// File: rtl/ldp_table.sv
module ldp_table #(
  parameter int ENTRIES = 1024,
  parameter int ADDR_W  = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IDX_W-1:0]    ra_idx,
  output logic [ADDR_W-1:0]   ra_last,
  output logic [ADDR_W-1:0]   ra_stride,
  output ldp_pkg::conf_t      ra_conf,
  input  logic [IDX_W-1:0]    rb_idx,
  output logic [ADDR_W-1:0]   rb_last,
  output logic [ADDR_W-1:0]   rb_stride,
  output ldp_pkg::conf_t      rb_conf,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [ADDR_W-1:0]   wr_last,
  input  logic                wr_stride_en,
  input  logic [ADDR_W-1:0]   wr_stride,
  input  ldp_pkg::conf_t      wr_conf
);

  logic [ADDR_W-1:0] last_q   [ENTRIES];
  logic [ADDR_W-1:0] stride_q [ENTRIES];
  ldp_pkg::conf_t    conf_q   [ENTRIES];

  assign ra_last   = last_q[ra_idx];
  assign ra_stride = stride_q[ra_idx];
  assign ra_conf   = conf_q[ra_idx];
  assign rb_last   = last_q[rb_idx];
  assign rb_stride = stride_q[rb_idx];
  assign rb_conf   = conf_q[rb_idx];

  // confidence: the only state that reset clears
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) conf_q[e] <= ldp_pkg::CONF_MIN;
    end else if (wr_en) begin
      conf_q[wr_idx] <= wr_conf;
    end
  end

  // address and step storage, enabled writes, no reset
  always_ff @(posedge clk) begin
    if (wr_en) last_q[wr_idx] <= wr_last;
    if (wr_en && wr_stride_en) stride_q[wr_idx] <= wr_stride;
  end

  AST_LAST_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en) |-> last_q[$past(wr_idx)] == $past(wr_last)); // R7

  AST_STRIDE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && !wr_stride_en) |-> stride_q[$past(wr_idx)] == $past(stride_q[wr_idx])); // R9

  AST_CONF_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en) |->
      ({1'b0, conf_q[$past(wr_idx)]} == {1'b0, $past(conf_q[wr_idx])}) ||
      ({1'b0, conf_q[$past(wr_idx)]} == {1'b0, $past(conf_q[wr_idx])} + 3'd1) ||
      ({1'b0, conf_q[$past(wr_idx)]} + 3'd1 == {1'b0, $past(conf_q[wr_idx])})); // R8

endmodule

// File: rtl/ldp_train.sv
module ldp_train #(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                up_valid,
  input  logic [ADDR_W-1:0]   real_addr,
  input  logic [LINE_W-1:0]   real_line,
  input  logic [ADDR_W-1:0]   pred_addr,
  input  logic [LINE_W-1:0]   pred_line,
  input  logic [ADDR_W-1:0]   old_last,
  input  ldp_pkg::conf_t      old_conf,
  output ldp_pkg::conf_t      new_conf,
  output logic                stride_en,
  output logic [ADDR_W-1:0]   new_stride,
  output logic                replay
);

  logic hit;

  always_comb begin
    hit        = (pred_addr == real_addr);
    new_conf   = ldp_pkg::conf_step(old_conf, hit);
    stride_en  = up_valid && !hit && (new_conf < ldp_pkg::CONF_USE);
    new_stride = real_addr - old_last;
    replay     = up_valid && old_conf[1] && (pred_line != real_line);
  end

  AST_CONF_TOP_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && hit && old_conf == ldp_pkg::CONF_MAX) |-> new_conf == ldp_pkg::CONF_MAX); // R8

  AST_CONF_FLOOR_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !hit && old_conf == ldp_pkg::CONF_MIN) |-> new_conf == ldp_pkg::CONF_MIN); // R8

  AST_STRIDE_KEPT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && old_conf == ldp_pkg::CONF_MAX) |-> !stride_en); // R9

  AST_SAME_LINE_NO_REPLAY: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_line == real_line) |-> !replay); // R6

endmodule

// File: rtl/ldp_stride_pred.sv
module ldp_stride_pred #(
  parameter int ENTRIES = 1024,
  parameter int ADDR_W  = 32,
  parameter int PC_W    = 32,
  parameter int PC_LSB  = 2,
  parameter int OFS_W   = 5,
  parameter int LINE_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [PC_W-1:0]   lk_pc,
  output logic              pr_valid,
  output logic [ADDR_W-1:0] pr_addr,
  output logic [LINE_W-1:0] pr_line,
  output logic              pr_use,
  input  logic              up_valid,
  input  logic [PC_W-1:0]   up_pc,
  input  logic [ADDR_W-1:0] up_addr,
  output logic              up_replay
);

  localparam int IDX_W = $clog2(ENTRIES);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  logic [IDX_W-1:0] lk_idx, up_idx;
  assign lk_idx = lk_pc[PC_LSB +: IDX_W];
  assign up_idx = up_pc[PC_LSB +: IDX_W];

  logic unused_pc_bits;
  assign unused_pc_bits = ^{lk_pc, up_pc};

  logic [ADDR_W-1:0] ra_last, ra_stride, rb_last, rb_stride;
  ldp_pkg::conf_t    ra_conf, rb_conf, wr_conf;
  logic              wr_stride_en;
  logic [ADDR_W-1:0] wr_stride;

  ldp_table #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_table (
    .clk(clk), .rst_n(rst_s),
    .ra_idx(lk_idx), .ra_last(ra_last), .ra_stride(ra_stride), .ra_conf(ra_conf),
    .rb_idx(up_idx), .rb_last(rb_last), .rb_stride(rb_stride), .rb_conf(rb_conf),
    .wr_en(up_valid), .wr_idx(up_idx), .wr_last(up_addr),
    .wr_stride_en(wr_stride_en), .wr_stride(wr_stride), .wr_conf(wr_conf)
  );

  // ---------------- lookup stage register (fetch -> decode) ----------------
  logic              v_q, v_d;
  logic [ADDR_W-1:0] last_q, last_d, stride_q, stride_d;
  ldp_pkg::conf_t    conf_q, conf_d;

  always_comb begin
    v_d      = lk_valid;
    last_d   = last_q;
    stride_d = stride_q;
    conf_d   = conf_q;
    if (lk_valid) begin
      last_d   = ra_last;
      stride_d = ra_stride;
      conf_d   = ra_conf;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) v_q <= 1'b0;
    else        v_q <= v_d;
  end

  always_ff @(posedge clk) begin
    last_q   <= last_d;
    stride_q <= stride_d;
    conf_q   <= conf_d;
  end

  // decode stage: add and hash in the same cycle
  assign pr_valid = v_q;
  assign pr_addr  = last_q + stride_q;
  assign pr_use   = v_q && conf_q[1];

  ldp_hash #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .LINE_W(LINE_W)) u_hash_lk (
    .addr(pr_addr), .line(pr_line)
  );

  // ---------------- resolve / training ----------------
  logic [ADDR_W-1:0] up_pred;
  logic [LINE_W-1:0] up_pred_line, up_real_line;

  assign up_pred = rb_last + rb_stride;

  ldp_hash #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .LINE_W(LINE_W)) u_hash_pred (
    .addr(up_pred), .line(up_pred_line)
  );
  ldp_hash #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .LINE_W(LINE_W)) u_hash_real (
    .addr(up_addr), .line(up_real_line)
  );

  ldp_train #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_train (
    .clk(clk), .rst_n(rst_s), .up_valid(up_valid),
    .real_addr(up_addr), .real_line(up_real_line),
    .pred_addr(up_pred), .pred_line(up_pred_line),
    .old_last(rb_last), .old_conf(rb_conf),
    .new_conf(wr_conf), .stride_en(wr_stride_en), .new_stride(wr_stride),
    .replay(up_replay)
  );

  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_s)
    lk_valid |=> pr_valid); // R2

  AST_USE_NEEDS_LOOKUP: assert property (@(posedge clk) disable iff (!rst_s)
    pr_use |-> $past(lk_valid)); // R4

  AST_REPLAY_NEEDS_UPDATE: assert property (@(posedge clk) disable iff (!rst_s)
    up_replay |-> up_valid); // R6

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_s |-> (!pr_valid && !pr_use)); // R1

endmodule

// File: tb/sim_ldp_stride_pred.sv
module sim_ldp_stride_pred;

  localparam int N  = 1024;
  localparam int AW = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid, up_valid;
  logic [31:0] lk_pc, up_pc, up_addr;
  logic        pr_valid, pr_use, up_replay;
  logic [31:0] pr_addr;
  logic [7:0]  pr_line;

  always #5 clk = ~clk;

  ldp_stride_pred u0 (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_pc(lk_pc),
    .pr_valid(pr_valid), .pr_addr(pr_addr), .pr_line(pr_line), .pr_use(pr_use),
    .up_valid(up_valid), .up_pc(up_pc), .up_addr(up_addr), .up_replay(up_replay)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // bench model of the table
  logic [31:0] m_last [N];
  logic [31:0] m_str  [N];
  logic [1:0]  m_cnt  [N];
  int          m_touch[N];

  logic        e_pv, e_use, e_known;
  logic [31:0] e_addr;

  function automatic logic [7:0] fold(input logic [31:0] a);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      r[i] = 1'b0;
      for (int p = 5 + i; p < 32; p += 8) r[i] = r[i] ^ a[p];
    end
    return r;
  endfunction

  function automatic int ix(input logic [31:0] pc);
    return int'(pc[11:2]);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit lv, input logic [31:0] lpc,
                      input bit uv, input logic [31:0] upc, input logic [31:0] ua);
    int li, ui;
    logic [31:0] pred;
    logic [1:0]  nc;
    bit hit, er;
    @(negedge clk);
    chk(pr_valid === e_pv, "R2 valid", {31'd0, pr_valid}, {31'd0, e_pv});
    if (e_pv) begin
      chk(pr_use === e_use, "R4 use", {31'd0, pr_use}, {31'd0, e_use});
      if (e_known) begin
        chk(pr_addr === e_addr, "R2 addr", pr_addr, e_addr);
        chk(pr_line === fold(e_addr), "R3 line", {24'd0, pr_line}, {24'd0, fold(e_addr)});
      end
    end
    lk_valid = lv; lk_pc = lpc; up_valid = uv; up_pc = upc; up_addr = ua;
    #1;
    ui = ix(upc);
    if (uv) begin
      pred = m_last[ui] + m_str[ui];
      er = m_cnt[ui][1] && (m_touch[ui] >= 2) && (fold(pred) != fold(ua));
      chk(up_replay === er, "R6 replay", {31'd0, up_replay}, {31'd0, er});
    end
    li      = ix(lpc);
    e_pv    = lv;
    e_use   = m_cnt[li][1];
    e_known = m_touch[li] >= 2;
    e_addr  = m_last[li] + m_str[li];
    if (uv) begin
      pred = m_last[ui] + m_str[ui];
      hit  = (m_touch[ui] >= 2) && (pred == ua);
      nc   = hit ? ((m_cnt[ui] == 2'd3) ? 2'd3 : m_cnt[ui] + 2'd1)
                 : ((m_cnt[ui] == 2'd0) ? 2'd0 : m_cnt[ui] - 2'd1);
      if (!hit && nc < 2'b10) m_str[ui] = ua - m_last[ui];
      m_cnt[ui]  = nc;
      m_last[ui] = ua;
      if (m_touch[ui] < 2) m_touch[ui]++;
    end
  endtask

  task automatic upd(input logic [31:0] pc, input logic [31:0] a);
    step(0, 32'd0, 1, pc, a);
  endtask

  task automatic look(input logic [31:0] pc);
    step(1, pc, 0, 32'd0, 32'd0);
    step(0, 32'd0, 0, 32'd0, 32'd0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; lk_valid = 0; up_valid = 0; e_pv = 0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(pr_valid === 1'b0 && pr_use === 1'b0, "R1 reset quiet",
          {30'd0, pr_valid, pr_use}, 32'd0);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int e = 0; e < N; e++) m_cnt[e] = 2'd0;
  endtask

  localparam logic [31:0] PA = 32'h0000_0100;

  initial begin
    rst_n = 1'b0; lk_valid = 0; up_valid = 0; lk_pc = 0; up_pc = 0; up_addr = 0;
    e_pv = 0; e_use = 0; e_known = 0; e_addr = 0;
    for (int e = 0; e < N; e++) begin
      m_last[e] = 0; m_str[e] = 0; m_cnt[e] = 0; m_touch[e] = 0;
    end
    void'($urandom(32'h5eed_0c1a));
    do_reset();

    // untrained lookup is not trusted
    look(PA);
    chk(pr_valid === 1'b1 && pr_use === 1'b0, "R1 untrained", {31'd0, pr_use}, 32'd0);

    // learn a 0x40 stream
    upd(PA, 32'h1000); upd(PA, 32'h1040); upd(PA, 32'h1080);
    look(PA);
    chk(pr_use === 1'b0, "R4 conf one", {31'd0, pr_use}, 32'd0);
    chk(pr_addr === 32'h10C0, "R2 pred", pr_addr, 32'h10C0);
    upd(PA, 32'h10C0);
    look(PA);
    chk(pr_use === 1'b1, "R4 conf two", {31'd0, pr_use}, 32'd1);
    chk(pr_addr === 32'h1100, "R2 pred", pr_addr, 32'h1100);
    upd(PA, 32'h1100); upd(PA, 32'h1140);

    // one miss from saturated: still trusted, step kept, last replaced
    upd(PA, 32'h2000);
    look(PA);
    chk(pr_use === 1'b1, "R8 sat then miss", {31'd0, pr_use}, 32'd1);
    chk(pr_addr === 32'h2040, "R9 stride kept / R7 last", pr_addr, 32'h2040);

    // second miss: wrong line -> replay, step relearned
    step(0, 0, 1, PA, 32'h3000);
    chk(up_replay === 1'b1, "R6 wrong line", {31'd0, up_replay}, 32'd1);
    look(PA);
    chk(pr_use === 1'b0, "R8 dec", {31'd0, pr_use}, 32'd0);
    chk(pr_addr === 32'h4000, "R9 stride new", pr_addr, 32'h4000);
    upd(PA, 32'h4000);
    look(PA);
    chk(pr_addr === 32'h5000 && pr_use === 1'b1, "R8 inc", pr_addr, 32'h5000);

    // wrong address inside the predicted line: no replay
    step(0, 0, 1, PA, 32'h5004);
    chk(up_replay === 1'b0, "R6 same line", {31'd0, up_replay}, 32'd0);
    look(PA);
    chk(pr_addr === 32'h6008, "R9 relearn", pr_addr, 32'h6008);

    // untagged aliasing
    look(PA + 32'h0000_1000);
    chk(pr_addr === 32'h6008, "R5 alias", pr_addr, 32'h6008);

    // lookup and update of one entry in the same cycle
    step(1, PA, 1, PA, 32'h7000);
    step(0, 0, 0, 0, 0);

    // reset clears trust but not addresses
    do_reset();
    upd(PA, 32'h8000); upd(PA, 32'h8010); upd(PA, 32'h8020); upd(PA, 32'h8030);
    look(PA);
    chk(pr_use === 1'b1, "R1 retrain", {31'd0, pr_use}, 32'd1);

    // random streams
    begin
      logic [31:0] base [8];
      logic [31:0] strd [8];
      for (int s = 0; s < 8; s++) begin
        base[s] = $urandom & 32'h0FFF_FFFC;
        strd[s] = ($urandom % 16) * 32'd8;
      end
      for (int n = 0; n < 4000; n++) begin
        int s, t, r;
        logic [31:0] a, lp;
        s = $urandom % 8;
        t = $urandom % 8;
        r = $urandom % 8;
        if (r < 5)       a = base[s] + strd[s];
        else if (r == 5) a = base[s] + strd[s] + 32'd4;
        else if (r == 6) a = $urandom & 32'hFFFF_FFFC;
        else begin strd[s] = ($urandom % 16) * 32'd8; a = base[s] + strd[s]; end
        base[s] = a;
        lp = 32'h200 + t * 4 + (($urandom % 2) << 12);
        step(($urandom % 4) != 0, lp, ($urandom % 8) != 0, 32'h200 + s * 4, a);
      end
    end
    step(0, 0, 0, 0, 0);

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule